// File: doc/BRIEF.md
# ALU operand forwarding selector

This block sits in the execute stage of a five-stage in-order pipeline. It picks the value that feeds each of the two ALU operand inputs. For each input it looks at the source register fields of the instruction now entering execute. It compares them with the destination registers of the two older instructions still in flight, one in the memory stage and one in write-back. When a match is found, the newer result is routed around the register file instead of the stale register value.

The upper input chooses from five values: register A, the next-PC value, the memory-stage ALU result, the write-back ALU result and the write-back load data. The lower input also chooses from five values: register B, the immediate, and the same three forwarded values. Each select code and the operand it produces are both output on the same cycle, with no registers inside the block. Stalling for a load followed at once by its use is handled elsewhere. This block only declines to forward a value that does not exist yet.

Top module: `alu_fwd_sel`

## Requirements
- R1: Select codes are 0 = register value (A or B), 1 = alternate (next PC on the upper input, immediate on the lower), 2 = memory-stage ALU result, 3 = write-back ALU result, 4 = write-back load data. With no forwarding, the upper select is 1 for a branch consumer and 0 for every other consumer.
- R2: With no forwarding, the lower select is 1 for an immediate-ALU, load, store or branch consumer, and 0 for a register-register or unrecognised consumer.
- R3: Bits are numbered MSB-first, so bit 0 is the top bit of the 32-bit word. The opcode is bits 0-5, with 0 = register-register ALU, 1 = immediate ALU, 2 = load, 3 = store, 4 = branch; any other value is unrecognised. A register-register producer writes the register in bits 16-20. An immediate-ALU or load producer writes the register in bits 11-15. Stores, branches and unrecognised instructions write nothing.
- R4: The upper input compares bits 6-10 of the consumer when the consumer is register-register, immediate ALU, load or store. The lower input compares bits 11-15 only when the consumer is register-register. On a match with a register-register or immediate-ALU producer in the memory stage, the select is 2.
- R5: On a match with a register-register or immediate-ALU producer in write-back, the select is 3.
- R6: On a match with a load producer in write-back, the select is 4.
- R7: When both older stages match the same source, the memory-stage value wins (select 2).
- R8: A destination of register 0 is never forwarded.
- R9: A load in the memory stage is never forwarded. Its consumer falls back to the write-back match or to the default.
- R10: Each operand output equals the data input named by its select code, in the same cycle.
- R11: The two inputs are selected independently, so they may forward from different stages at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_ir | input | 32 | Instruction entering execute (consumer) |
| exm_ir | input | 32 | Instruction in the memory stage |
| wb_ir | input | 32 | Instruction in write-back |
| reg_a | input | XLEN | First register-file operand |
| reg_b | input | XLEN | Second register-file operand |
| npc | input | XLEN | Next-PC value of the consumer |
| imm | input | XLEN | Sign-extended immediate of the consumer |
| exm_alu | input | XLEN | ALU result held in the memory stage |
| wb_alu | input | XLEN | ALU result held in write-back |
| wb_lmd | input | XLEN | Load data held in write-back |
| sel_hi | output | 3 | Upper operand select code |
| sel_lo | output | 3 | Lower operand select code |
| alu_hi | output | XLEN | Upper ALU operand |
| alu_lo | output | XLEN | Lower ALU operand |

## Verification
The hardest cases arise when the wrong destination field holds a matching register number. Examples are a register-register producer whose bits 11-15 happen to equal the consumer source, or a load sitting in the memory stage that matches while write-back also matches. The stimulus reaches these by sweeping every pairing of six instruction classes across the three stages over a four-register set. In each producer, the field that is not the destination is filled with a different register number. Directed sequences then cover back-to-back use, one-apart use, load-then-use, the register 0 case and the field-position case.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int IR_W  = 32;
    localparam int OPC_W = 6;
    localparam int RIX_W = 5;

    localparam logic [OPC_W-1:0] OPC_RR = 6'd0;
    localparam logic [OPC_W-1:0] OPC_RI = 6'd1;
    localparam logic [OPC_W-1:0] OPC_LD = 6'd2;
    localparam logic [OPC_W-1:0] OPC_ST = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BR = 6'd4;

    typedef enum logic [2:0] {
        SEL_REG   = 3'd0,
        SEL_ALT   = 3'd1,
        SEL_EXMEM = 3'd2,
        SEL_WBALU = 3'd3,
        SEL_WBLMD = 3'd4
    } opsel_e;

    typedef enum logic [2:0] {
        CL_RR, CL_RI, CL_LD, CL_ST, CL_BR, CL_NONE
    } iclass_e;

    typedef struct packed {
        iclass_e            cls;
        logic [RIX_W-1:0]   src_hi;
        logic [RIX_W-1:0]   src_lo;
        logic [RIX_W-1:0]   dst;
        logic               dst_vld;
    } idec_t;

    function automatic iclass_e classify(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_RR:  return CL_RR;
            OPC_RI:  return CL_RI;
            OPC_LD:  return CL_LD;
            OPC_ST:  return CL_ST;
            OPC_BR:  return CL_BR;
            default: return CL_NONE;
        endcase
    endfunction

    // MSB-first field numbering: bits 0-5 -> [31:26], 6-10 -> [25:21],
    // 11-15 -> [20:16], 16-20 -> [15:11]
    function automatic idec_t decode(input logic [IR_W-1:0] ir);
        idec_t d;
        d.cls    = classify(ir[31:26]);
        d.src_hi = ir[25:21];
        d.src_lo = ir[20:16];
        case (d.cls)
            CL_RR:        d.dst = ir[15:11];
            CL_RI, CL_LD: d.dst = ir[20:16];
            default:      d.dst = '0;
        endcase
        d.dst_vld = (d.dst != '0);
        return d;
    endfunction

endpackage

// File: rtl/fwd_decode.sv
module fwd_decode
    import fwd_pkg::*;
(
    input  logic [IR_W-1:0] ir,
    output idec_t           dec
);
    logic unused_low;
    assign unused_low = ^ir[10:0];
    assign dec = decode(ir);
endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
    import fwd_pkg::*;
#(
    parameter bit IS_UPPER = 1'b1
) (
    input  idec_t  cons,
    input  idec_t  exm,
    input  idec_t  wb,
    output opsel_e sel
);
    logic             uses_fwd;
    logic [RIX_W-1:0] idx;
    opsel_e           dflt;
    logic             hit_exm;
    logic             hit_wb;
    logic             unused_fields;

    assign unused_fields = ^{cons, exm, wb};

    generate
        if (IS_UPPER) begin : g_upper
            always_comb begin
                uses_fwd = (cons.cls == CL_RR) || (cons.cls == CL_RI) ||
                           (cons.cls == CL_LD) || (cons.cls == CL_ST);
                idx      = cons.src_hi;
                dflt     = (cons.cls == CL_BR) ? SEL_ALT : SEL_REG;
            end
        end else begin : g_lower
            always_comb begin
                uses_fwd = (cons.cls == CL_RR);
                idx      = cons.src_lo;
                dflt     = (cons.cls == CL_RR || cons.cls == CL_NONE) ? SEL_REG : SEL_ALT;
            end
        end
    endgenerate

    // a load still in the memory stage has no data yet
    assign hit_exm = uses_fwd && exm.dst_vld && (exm.cls != CL_LD) && (exm.dst == idx);
    assign hit_wb  = uses_fwd && wb.dst_vld && (wb.dst == idx);

    always_comb begin
        if (hit_exm)     sel = SEL_EXMEM;
        else if (hit_wb) sel = (wb.cls == CL_LD) ? SEL_WBLMD : SEL_WBALU;
        else             sel = dflt;
    end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  opsel_e          sel,
    input  logic [XLEN-1:0] reg_v,
    input  logic [XLEN-1:0] alt_v,
    input  logic [XLEN-1:0] exm_v,
    input  logic [XLEN-1:0] wba_v,
    input  logic [XLEN-1:0] wbl_v,
    output logic [XLEN-1:0] y
);
    always_comb begin
        unique case (sel)
            SEL_ALT:   y = alt_v;
            SEL_EXMEM: y = exm_v;
            SEL_WBALU: y = wba_v;
            SEL_WBLMD: y = wbl_v;
            default:   y = reg_v;
        endcase
    end
endmodule

// File: rtl/alu_fwd_sel.sv
module alu_fwd_sel
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [IR_W-1:0] id_ir,
    input  logic [IR_W-1:0] exm_ir,
    input  logic [IR_W-1:0] wb_ir,
    input  logic [XLEN-1:0] reg_a,
    input  logic [XLEN-1:0] reg_b,
    input  logic [XLEN-1:0] npc,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] exm_alu,
    input  logic [XLEN-1:0] wb_alu,
    input  logic [XLEN-1:0] wb_lmd,
    output logic [2:0]      sel_hi,
    output logic [2:0]      sel_lo,
    output logic [XLEN-1:0] alu_hi,
    output logic [XLEN-1:0] alu_lo
);
    localparam int NSTG = 3;
    localparam int NOPD = 2;

    logic [NSTG-1:0][IR_W-1:0] ir_all;
    idec_t                     dec_all [NSTG];
    logic [NOPD-1:0][XLEN-1:0] reg_vals;
    logic [NOPD-1:0][XLEN-1:0] alt_vals;
    logic [NOPD-1:0][XLEN-1:0] res_vals;
    opsel_e                    sel_vals [NOPD];

    assign ir_all   = {wb_ir, exm_ir, id_ir};
    assign reg_vals = {reg_b, reg_a};
    assign alt_vals = {imm, npc};

    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_dec
            fwd_decode u_dec (
                .ir  (ir_all[s]),
                .dec (dec_all[s])
            );
        end

        for (genvar k = 0; k < NOPD; k++) begin : g_opd
            fwd_src_pick #(.IS_UPPER(k == 0)) u_pick (
                .cons (dec_all[0]),
                .exm  (dec_all[1]),
                .wb   (dec_all[2]),
                .sel  (sel_vals[k])
            );
            fwd_opmux #(.XLEN(XLEN)) u_mux (
                .sel   (sel_vals[k]),
                .reg_v (reg_vals[k]),
                .alt_v (alt_vals[k]),
                .exm_v (exm_alu),
                .wba_v (wb_alu),
                .wbl_v (wb_lmd),
                .y     (res_vals[k])
            );
        end
    endgenerate

    assign sel_hi = sel_vals[0];
    assign sel_lo = sel_vals[1];
    assign alu_hi = res_vals[0];
    assign alu_lo = res_vals[1];
endmodule

// File: rtl/alu_fwd_sel_chk.sv
module alu_fwd_sel_chk
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic [IR_W-1:0] id_ir,
    input logic [IR_W-1:0] exm_ir,
    input logic [IR_W-1:0] wb_ir,
    input logic [XLEN-1:0] npc,
    input logic [XLEN-1:0] imm,
    input logic [XLEN-1:0] exm_alu,
    input logic [XLEN-1:0] wb_alu,
    input logic [XLEN-1:0] wb_lmd,
    input logic [2:0]      sel_hi,
    input logic [2:0]      sel_lo,
    input logic [XLEN-1:0] alu_hi,
    input logic [XLEN-1:0] alu_lo
);
    logic unused_bits;
    assign unused_bits = ^{id_ir[25:0], wb_ir[25:0], exm_ir[25:21], exm_ir[10:0]};

    always_comb begin
        if (!$isunknown({id_ir, exm_ir, wb_ir, sel_hi, sel_lo})) begin
            // R1
            br_hi_chk: assert (id_ir[31:26] != OPC_BR || (sel_hi == SEL_ALT && alu_hi == npc));
            // R2
            imm_lo_chk: assert (!(id_ir[31:26] inside {OPC_RI, OPC_LD, OPC_ST, OPC_BR})
                                || (sel_lo == SEL_ALT && alu_lo == imm));
            // R4
            exm_fwd_chk: assert ((sel_hi != SEL_EXMEM || alu_hi == exm_alu) &&
                                 (sel_lo != SEL_EXMEM || alu_lo == exm_alu) &&
                                 ((sel_hi != SEL_EXMEM && sel_lo != SEL_EXMEM) ||
                                  exm_ir[31:26] inside {OPC_RR, OPC_RI}));
            // R5
            wb_alu_chk: assert ((sel_hi != SEL_WBALU && sel_lo != SEL_WBALU) ||
                                (wb_ir[31:26] inside {OPC_RR, OPC_RI}));
            // R6
            wb_lmd_chk: assert ((sel_hi != SEL_WBLMD || alu_hi == wb_lmd) &&
                                (sel_lo != SEL_WBLMD || alu_lo == wb_lmd) &&
                                ((sel_hi != SEL_WBLMD && sel_lo != SEL_WBLMD) ||
                                 wb_ir[31:26] == OPC_LD));
            // R8
            zero_dst_chk: assert (!(exm_ir[20:16] == '0 && exm_ir[15:11] == '0) ||
                                  (sel_hi != SEL_EXMEM && sel_lo != SEL_EXMEM));
            // R9
            ld_exm_chk: assert (exm_ir[31:26] != OPC_LD ||
                                (sel_hi != SEL_EXMEM && sel_lo != SEL_EXMEM));
            // R10
            sel_range_chk: assert (sel_hi <= 3'd4 && sel_lo <= 3'd4 &&
                                   (sel_hi != SEL_WBALU || alu_hi == wb_alu) &&
                                   (sel_lo != SEL_WBALU || alu_lo == wb_alu));
        end
    end
endmodule

bind alu_fwd_sel alu_fwd_sel_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_alu_fwd_sel.sv
module tb_alu_fwd_sel;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0]     id_ir, exm_ir, wb_ir;
    logic [XLEN-1:0] reg_a, reg_b, npc, imm, exm_alu, wb_alu, wb_lmd;
    logic [2:0]      sel_hi, sel_lo;
    logic [XLEN-1:0] alu_hi, alu_lo;

    int n_chk  = 0;
    int n_fail = 0;

    alu_fwd_sel #(.XLEN(XLEN)) dut (.*);

    localparam logic [5:0] OP_LIST [6] = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'h2A};

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] f6,
                                       input logic [4:0] f11, input logic [4:0] f16);
        return {op, f6, f11, f16, 11'h155};
    endfunction

    // destination per R3; 0 means none
    function automatic int dst_of(input logic [31:0] ir);
        int op = int'(ir[31:26]);
        if (op == 0) return int'(ir[15:11]);
        if (op == 1 || op == 2) return int'(ir[20:16]);
        return 0;
    endfunction

    function automatic int exp_sel(input bit up, input logic [31:0] c,
                                   input logic [31:0] p1, input logic [31:0] p2);
        int cop = int'(c[31:26]);
        int src = up ? int'(c[25:21]) : int'(c[20:16]);
        bit can = up ? (cop <= 3) : (cop == 0);
        if (can && src != 0) begin
            if (int'(p1[31:26]) != 2 && dst_of(p1) == src) return 2;
            if (dst_of(p2) == src) return (int'(p2[31:26]) == 2) ? 4 : 3;
        end
        if (up) return (cop == 4) ? 1 : 0;
        return (cop >= 1 && cop <= 4) ? 1 : 0;
    endfunction

    function automatic logic [XLEN-1:0] val_of(input bit up, input int s);
        case (s)
            1: return up ? npc : imm;
            2: return exm_alu;
            3: return wb_alu;
            4: return wb_lmd;
            default: return up ? reg_a : reg_b;
        endcase
    endfunction

    task automatic apply(input logic [31:0] c, input logic [31:0] p1, input logic [31:0] p2);
        @(posedge clk);
        id_ir = c; exm_ir = p1; wb_ir = p2;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        int eh = exp_sel(1'b1, id_ir, exm_ir, wb_ir);
        int el = exp_sel(1'b0, id_ir, exm_ir, wb_ir);
        n_chk++;
        if (int'(sel_hi) != eh || int'(sel_lo) != el ||
            alu_hi != val_of(1'b1, eh) || alu_lo != val_of(1'b0, el)) begin
            n_fail++;
            $display("FAIL %s: sel %0d/%0d op %h/%h expected sel %0d/%0d op %h/%h ir %h %h %h",
                     tag, sel_hi, sel_lo, alu_hi, alu_lo, eh, el,
                     val_of(1'b1, eh), val_of(1'b0, el), id_ir, exm_ir, wb_ir);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        reg_a = 32'hAAAA_0001; reg_b = 32'hBBBB_0002; npc = 32'h0000_1004;
        imm = 32'h0000_0040; exm_alu = 32'hE0E0_0005; wb_alu = 32'hD0D0_0006;
        wb_lmd = 32'hC0C0_0007;

        // idle: all bubbles (unrecognised opcode)
        apply(mk(6'h2A, 5'd1, 5'd1, 5'd1), mk(6'h2A, 5'd1, 5'd1, 5'd1), mk(6'h2A, 5'd1, 5'd1, 5'd1));
        chk("R1 idle upper", int'(sel_hi), 0);
        chk("R2 idle lower", int'(sel_lo), 0);

        // branch and immediate consumer defaults
        apply(mk(6'd4, 5'd3, 5'd3, 5'd0), mk(6'd0, 5'd0, 5'd0, 5'd3), mk(6'h2A, 5'd0, 5'd0, 5'd0));
        chk("R1 branch takes next PC", int'(alu_hi), int'(npc));
        chk("R2 branch takes immediate", int'(alu_lo), int'(imm));

        // R3 field position: RR producer writes bits 16-20 (=5), bits 11-15 hold 9
        apply(mk(6'd0, 5'd9, 5'd0, 5'd0), mk(6'd0, 5'd1, 5'd9, 5'd5), mk(6'h2A, 5'd0, 5'd0, 5'd0));
        chk("R3 rr dest not in bits 11-15", int'(sel_hi), 0);
        apply(mk(6'd0, 5'd5, 5'd0, 5'd0), mk(6'd0, 5'd1, 5'd9, 5'd5), mk(6'h2A, 5'd0, 5'd0, 5'd0));
        chk("R3 rr dest in bits 16-20", int'(sel_hi), 2);

        // R4 back-to-back: add r1 then add r4,r5,r1
        apply(mk(6'd0, 5'd5, 5'd1, 5'd4), mk(6'd0, 5'd2, 5'd3, 5'd1), mk(6'h2A, 5'd0, 5'd0, 5'd0));
        chk("R4 back-to-back lower", int'(alu_lo), int'(exm_alu));
        // R4 store base from immediate producer
        apply(mk(6'd3, 5'd7, 5'd4, 5'd0), mk(6'd1, 5'd2, 5'd7, 5'd0), mk(6'h2A, 5'd0, 5'd0, 5'd0));
        chk("R4 store base forwarded", int'(sel_hi), 2);

        // R5 one apart
        apply(mk(6'd1, 5'd1, 5'd4, 5'd0), mk(6'h2A, 5'd0, 5'd0, 5'd0), mk(6'd0, 5'd2, 5'd3, 5'd1));
        chk("R5 one-apart upper", int'(alu_hi), int'(wb_alu));

        // R6 load-then-use (after stall): load in write-back
        apply(mk(6'd0, 5'd1, 5'd5, 5'd4), mk(6'h2A, 5'd0, 5'd0, 5'd0), mk(6'd2, 5'd2, 5'd1, 5'd0));
        chk("R6 load data forwarded", int'(alu_hi), int'(wb_lmd));

        // R7 both stages match r6
        apply(mk(6'd0, 5'd6, 5'd6, 5'd2), mk(6'd0, 5'd0, 5'd0, 5'd6), mk(6'd1, 5'd0, 5'd6, 5'd0));
        chk("R7 newer wins upper", int'(sel_hi), 2);
        chk("R7 newer wins lower", int'(sel_lo), 2);

        // R8 writes to register 0
        apply(mk(6'd0, 5'd0, 5'd0, 5'd3), mk(6'd0, 5'd0, 5'd0, 5'd0), mk(6'd1, 5'd0, 5'd0, 5'd0));
        chk("R8 r0 upper", int'(sel_hi), 0);
        chk("R8 r0 lower", int'(sel_lo), 0);

        // R9 load in memory stage, older ALU match in write-back
        apply(mk(6'd0, 5'd3, 5'd2, 5'd1), mk(6'd2, 5'd0, 5'd3, 5'd0), mk(6'd0, 5'd0, 5'd0, 5'd3));
        chk("R9 load in memory stage skipped", int'(sel_hi), 3);

        // R10 and R11: upper from write-back load, lower from memory stage
        apply(mk(6'd0, 5'd8, 5'd9, 5'd1), mk(6'd0, 5'd0, 5'd0, 5'd9), mk(6'd2, 5'd0, 5'd8, 5'd0));
        chk("R11 independent upper", int'(sel_hi), 4);
        chk("R11 independent lower", int'(sel_lo), 2);
        chk("R10 upper value", int'(alu_hi), int'(wb_lmd));
        chk("R10 lower value", int'(alu_lo), int'(exm_alu));

        // sweep: every class triple over registers 0..3, wrong field holds d^1
        for (int ci = 0; ci < 6; ci++)
            for (int pi = 0; pi < 6; pi++)
                for (int wi = 0; wi < 6; wi++)
                    for (int d1 = 0; d1 < 4; d1++)
                        for (int d2 = 0; d2 < 4; d2++)
                            for (int s1 = 0; s1 < 4; s1++)
                                for (int s2 = 0; s2 < 4; s2++) begin
                                    logic [31:0] c, p1, p2;
                                    c  = mk(OP_LIST[ci], 5'(s1), 5'(s2), 5'(s1 ^ 3));
                                    p1 = (pi == 0) ? mk(OP_LIST[pi], 5'd3, 5'(d1 ^ 1), 5'(d1))
                                                   : mk(OP_LIST[pi], 5'd3, 5'(d1), 5'(d1 ^ 1));
                                    p2 = (wi == 0) ? mk(OP_LIST[wi], 5'd2, 5'(d2 ^ 1), 5'(d2))
                                                   : mk(OP_LIST[wi], 5'd2, 5'(d2), 5'(d2 ^ 1));
                                    apply(c, p1, p2);
                                    chk_all("R1/R2/R3/R4/R5/R6/R7/R8/R9/R10/R11 sweep");
                                end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule